// File: doc/BRIEF.md
# Flow-Through Burst Memory

A behavioural single-port synchronous memory with one 32-bit data word split into four byte lanes. The depth is set by a parameter. On each rising clock edge the block samples the address, three chip-select inputs, two address strobes, an advance input and the write controls. From these it decides whether the cycle is a deselect, a new read, a new write, a burst step or a burst pause. Within a burst a two-bit counter forms the low two address bits, in either a linear or an interleaved order. Read data is not pipelined: the word at the registered address appears on `dout` in the same cycle.

The two strobes have a fixed priority. The processor strobe wins when both are low, and it is gated by the first chip select. A burst started by the processor strobe always reads in its first cycle. The byte-lane data path has a global-write override. A sleep input stops all accesses and keeps the stored contents. The bidirectional bus is split into `din`, `dout` and a drive-enable output `dout_en`. Output enable acts as a combinational gate on `dout_en`.

Top module: `burst_sram`

## Requirements
- R1: After reset `dout_en` is low, and no burst is active.
- R2: A strobe cycle selects the block only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Any other strobe cycle is a deselect. It drives no data and ends the burst, so a following advance cycle with no strobe does nothing.
- R3: When both strobes are low, only `strb_cpu_n` is honoured. `strb_cpu_n` is ignored whenever `sel_a_n` is high.
- R4: A burst opened by `strb_cpu_n` reads in its first cycle, whatever the write inputs are.
- R5: A burst opened by `strb_ctl_n` writes in its first cycle when the write inputs are active, and reads otherwise.
- R6: The write inputs are active when `wr_all_n`=0, which writes all lanes. They are also active when `lane_wr_n`=0 and at least one bit of `lane_sel_n` is 0, which writes only those lanes; bit 0 selects bits 7:0 and bit 3 selects bits 31:24. `lane_sel_n` has no effect while `lane_wr_n`=1.
- R7: The low two address bits equal start+n mod 4 when `burst_ilv`=0, and start XOR n when `burst_ilv`=1. Here n counts the advances since the strobe, and `burst_ilv` is captured with the strobe.
- R8: In a cycle with no strobe during a burst, `step_n`=0 moves to the next address and `step_n`=1 keeps the current one. Either kind of cycle writes when the write inputs are active.
- R9: Read data for the registered address appears on `dout` after the same clock edge. `dout_en` is high only while `oe_n`=0.
- R10: `dout_en` is low in every write cycle. After a write it stays low through pause cycles that do not write, until a strobe or an advance read.
- R11: While `sleep` is high no access takes place, `dout_en` is low and the contents are kept. The first two edges after `sleep` falls are also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address sampled with a strobe |
| sel_a_n | input | 1 | Chip select, active low; also gates the processor strobe |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| strb_cpu_n | input | 1 | Processor address strobe, active low |
| strb_ctl_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write, active low |
| lane_wr_n | input | 1 | Byte-lane write enable, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| burst_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| oe_n | input | 1 | Output enable, active low, combinational |
| sleep | input | 1 | Sleep request, active high |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Flow-through read data |
| dout_en | output | 1 | High when the block drives the data bus |

## Verification
The bench looks for the following mistakes:
- Strobe priority. It raises both strobes together with write inputs active. A design that let the controller strobe win would write instead of read. It also raises both strobes with the first select high; a design that did not deselect there would drive data.
- Burst order. It walks complete linear and interleaved wraps. An error in the low address bits shows as the wrong stored word.
- Lane mask. It gives lane selects without the lane enable. A design that treated the selects as enough would show the write data instead of the old word.
- Bus release. After a pause-cycle write it checks that a following pause read stays undriven, while an advance read drives again.
- Sleep exit. A design with too short a sleep-exit window would accept a strobe one or two cycles early, and would overwrite data during sleep.

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    strb_cpu_n,
  input  logic                    strb_ctl_n,
  input  logic                    step_n,
  input  logic                    wr_all_n,
  input  logic                    lane_wr_n,
  input  logic [LANES-1:0]        lane_sel_n,
  input  logic                    burst_ilv,
  input  logic                    oe_n,
  input  logic                    sleep,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HI_W  = ADDR_W - 2;

  logic [DW-1:0]   mem [DEPTH];
  logic [HI_W-1:0] base_q;
  logic [1:0]      first_q, cnt_q;
  logic            ilv_q, active_q, rd_q, z1_q, z2_q;

  function automatic logic [1:0] order(input logic [1:0] s, input logic [1:0] n, input logic ilv);
    return ilv ? (s ^ n) : (s + n);
  endfunction

  wire blocked = sleep | z1_q | z2_q;
  wire sel     = ~sel_a_n & sel_b & ~sel_c_n;
  wire cpu_go  = ~strb_cpu_n & ~sel_a_n;
  wire ctl_go  = ~strb_ctl_n & ~cpu_go;
  wire start   = cpu_go | ctl_go;
  wire any_wr  = ~wr_all_n | (~lane_wr_n & ~(&lane_sel_n));
  wire step    = ~blocked & ~start & active_q & ~step_n;

  wire [LANES-1:0]  lane_we  = ~wr_all_n ? '1 : (~lane_wr_n ? ~lane_sel_n : '0);
  wire [1:0]        cnt_nx   = step ? cnt_q + 2'd1 : cnt_q;
  wire [ADDR_W-1:0] cur_addr = {base_q, order(first_q, cnt_q, ilv_q)};
  wire [ADDR_W-1:0] acc_addr = start ? addr : {base_q, order(first_q, cnt_nx, ilv_q)};
  wire do_write = ~blocked & any_wr & ((ctl_go & sel) | (~start & active_q));

  assign dout    = mem[cur_addr];
  assign dout_en = rd_q & ~oe_n & ~blocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      z1_q     <= 1'b0;
      z2_q     <= 1'b0;
      cnt_q    <= '0;
      first_q  <= '0;
      base_q   <= '0;
      ilv_q    <= 1'b0;
    end else begin
      z1_q <= sleep;
      z2_q <= z1_q;
      if (blocked) begin
        active_q <= 1'b0;
        rd_q     <= 1'b0;
      end else if (start) begin
        if (sel) begin
          active_q <= 1'b1;
          base_q   <= addr[ADDR_W-1:2];
          first_q  <= addr[1:0];
          cnt_q    <= '0;
          ilv_q    <= burst_ilv;
          rd_q     <= ~(ctl_go & any_wr);
        end else begin
          active_q <= 1'b0;
          rd_q     <= 1'b0;
        end
      end else if (active_q) begin
        cnt_q <= cnt_nx;
        if (any_wr)       rd_q <= 1'b0;
        else if (~step_n) rd_q <= 1'b1;
      end else begin
        rd_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_write)
      for (int i = 0; i < LANES; i++)
        if (lane_we[i]) mem[acc_addr][i*LANE_W +: LANE_W] <= din[i*LANE_W +: LANE_W];
  end

  a_r2_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (start & ~sel & ~blocked) |=> !dout_en);
  a_r4_cpu_strobe_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_go & sel & ~blocked) |=> (sleep || (dout_en == !oe_n)));
  a_r8_pause_holds_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q & ~start & step_n & ~blocked) |=> $stable(cur_addr));
  a_r10_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q & ~start & any_wr & ~blocked) |=> !dout_en);
  a_r11_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !dout_en);
endmodule

// File: tb/burst_sram_test.sv
`timescale 1ns/1ps
module burst_sram_test;
  logic clk = 0, rst_n = 0;
  logic [5:0] addr = '0;
  logic sel_a_n = 0, sel_b = 1, sel_c_n = 0;
  logic strb_cpu_n = 1, strb_ctl_n = 1, step_n = 1, wr_all_n = 1, lane_wr_n = 1;
  logic [3:0] lane_sel_n = 4'hF;
  logic burst_ilv = 0, oe_n = 0, sleep = 0;
  logic [31:0] din = '0, dout;
  logic dout_en;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  burst_sram uut (.clk(clk), .rst_n(rst_n), .addr(addr), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .step_n(step_n),
    .wr_all_n(wr_all_n), .lane_wr_n(lane_wr_n), .lane_sel_n(lane_sel_n), .burst_ilv(burst_ilv),
    .oe_n(oe_n), .sleep(sleep), .din(din), .dout(dout), .dout_en(dout_en));

  typedef struct packed {
    logic ps_n, cs_n, st_n, ga_n, lw_n;
    logic [3:0] ls_n;
    logic sa_n, sb, sc_n, oe, ilv;
    logic [5:0] a;
    logic [31:0] d;
    logic en;
    logic [31:0] q;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{1,0,1,0,1,4'hF,0,1,0,0,0,6'd4,32'hA0000000,0,32'h0},        // R5 R6 global write opens burst
    '{1,1,0,0,1,4'hF,0,1,0,0,0,6'd0,32'hA1000000,0,32'h0},        // R8 advance write
    '{1,1,0,0,1,4'hF,0,1,0,0,0,6'd0,32'hA2000000,0,32'h0},        // R8
    '{1,1,0,0,1,4'hF,0,1,0,0,0,6'd0,32'hA3000000,0,32'h0},        // R8 R10
    '{1,1,1,1,1,4'hF,0,1,0,0,0,6'd0,32'h0,0,32'h0},               // R10 pause after write stays off
    '{0,1,1,0,1,4'hF,0,1,0,0,0,6'd6,32'hFFFFFFFF,1,32'hA2000000}, // R4 forced read, R9
    '{1,1,0,1,1,4'hF,0,1,0,0,0,6'd0,32'h0,1,32'hA3000000},        // R7 linear
    '{1,1,0,1,1,4'hF,0,1,0,0,0,6'd0,32'h0,1,32'hA0000000},        // R7 wrap
    '{1,1,1,1,1,4'hF,0,1,0,0,0,6'd0,32'h0,1,32'hA0000000},        // R8 pause
    '{1,1,0,1,1,4'hF,0,1,0,0,0,6'd0,32'h0,1,32'hA1000000},        // R7
    '{0,1,1,1,1,4'hF,0,1,0,0,1,6'd6,32'h0,1,32'hA2000000},        // R7 interleaved start
    '{1,1,0,1,1,4'hF,0,1,0,0,0,6'd0,32'h0,1,32'hA3000000},        // R7
    '{1,1,0,1,1,4'hF,0,1,0,0,0,6'd0,32'h0,1,32'hA0000000},        // R7
    '{1,1,0,1,1,4'hF,0,1,0,0,0,6'd0,32'h0,1,32'hA1000000},        // R7
    '{1,1,0,1,1,4'hF,0,1,0,1,0,6'd0,32'h0,0,32'h0},               // R9 oe high
    '{1,0,1,1,0,4'b1010,0,1,0,0,0,6'd4,32'h11223344,0,32'h0},     // R6 lanes 0 and 2
    '{1,0,1,1,1,4'hF,0,1,0,0,0,6'd4,32'h0,1,32'hA0220044},        // R5 read, R6 result
    '{0,0,1,0,1,4'hF,0,1,0,0,0,6'd5,32'hFFFFFFFF,1,32'hA1000000}, // R3 both strobes
    '{0,0,1,0,1,4'hF,1,1,0,0,0,6'd6,32'h0,0,32'h0},               // R2 R3 first select high
    '{0,1,1,1,1,4'hF,0,0,0,0,0,6'd4,32'h0,0,32'h0},               // R2 second select low
    '{1,1,0,1,1,4'hF,0,1,0,0,0,6'd0,32'h0,0,32'h0},               // R2 no burst after deselect
    '{1,0,1,1,1,4'hF,0,1,1,0,0,6'd4,32'h0,0,32'h0},               // R2 third select high
    '{1,0,1,1,1,4'h0,0,1,0,0,0,6'd7,32'hFFFFFFFF,1,32'hA3000000}, // R6 selects without enable
    '{1,1,1,0,1,4'hF,0,1,0,0,0,6'd0,32'h55555555,0,32'h0},        // R8 R10 pause write
    '{1,1,0,1,1,4'hF,0,1,0,0,0,6'd0,32'h0,1,32'hA0220044},        // R10 advance read drives
    '{1,0,1,1,1,4'hF,0,1,0,0,0,6'd7,32'h0,1,32'h55555555}         // R8 pause write landed
  };

  task automatic check(input string req, input logic en, input logic [31:0] q);
    checks++;
    if (dout_en !== en || (en && dout !== q)) begin
      fails++;
      $display("FAIL %s: dout_en=%0b dout=%h expected dout_en=%0b dout=%h", req, dout_en, dout, en, q);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    strb_cpu_n = v.ps_n; strb_ctl_n = v.cs_n; step_n = v.st_n; wr_all_n = v.ga_n;
    lane_wr_n = v.lw_n; lane_sel_n = v.ls_n; sel_a_n = v.sa_n; sel_b = v.sb;
    sel_c_n = v.sc_n; oe_n = v.oe; burst_ilv = v.ilv; addr = v.a; din = v.d;
    @(posedge clk); #1;
  endtask

  localparam vec_t IDLE = '{1,1,1,1,1,4'hF,0,1,0,0,0,6'd0,32'h0,0,32'h0};
  localparam vec_t RD4  = '{1,0,1,1,1,4'hF,0,1,0,0,0,6'd4,32'h0,0,32'h0};
  localparam vec_t WR4  = '{1,0,1,0,1,4'hF,0,1,0,0,0,6'd4,32'hDEADBEEF,0,32'h0};

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; check("R1", 1'b0, '0);
    @(negedge clk); rst_n = 1;
    drive(IDLE); check("R1", 1'b0, '0);
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      check($sformatf("vector %0d", i), VECS[i].en, VECS[i].q);
    end
    sleep = 1;
    drive(IDLE); check("R11 asleep", 1'b0, '0);
    drive(WR4);  check("R11 strobe while asleep", 1'b0, '0);
    sleep = 0;
    drive(RD4);  check("R11 exit cycle 1", 1'b0, '0);
    drive(RD4);  check("R11 exit cycle 2", 1'b0, '0);
    drive(RD4);  check("R11 contents kept", 1'b1, 32'hA0220044);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule